// File: doc/BRIEF.md
# Compare-Match Square-Wave Generator

This block turns a pair of prescaled up-counters into pin-level events. Each of two compare channels holds a 16-bit threshold and watches the counter that the time-base selector routes to it. When the routed counter is about to step onto the threshold, the channel performs its configured action on its output pin. The action is one of force high, force low or invert. The same event also raises a sticky interrupt flag. In the invert action the counter is sent back to zero instead of stepping, so the pin produces a wave with equal high and low times. Each half of that wave lasts exactly threshold × prescale clock cycles.

The counters and thresholds are loaded a byte at a time through one write port. Both counters are visible on an output bus. Each counter can run in a narrow 8-bit form or a full 16-bit form, and the form also sets how many bits the compare looks at. The clock of the block is taken as the instruction clock, which is one quarter of the oscillator. A compare value of 250 with the divide-by-8 setting therefore gives a 1 ms half-period from a 2 MHz tick source.

Top module: `cmp_wave_gen`

## Requirements
- R1: After reset, both pins, both flags, both counters and both compare registers read 0.
- R2: A running counter advances once every 1, 2, 4 or 8 clock cycles for `presc_code` 00, 01, 10 and 11.
- R3: A write with `wr_hi`=0 replaces bits 7:0 of the target and a write with `wr_hi`=1 replaces bits 15:8. The other byte is kept. `wr_tgt` selects the target: 00 is the compare register of channel 0, 01 is the compare register of channel 1, 10 is counter A and 11 is counter B. A counter write takes priority over counting in the same cycle.
- R4: A match is an advance step in which counter+1 equals the compare value. Mode 01 then drives the pin to 1 and mode 10 drives it to 0. In both modes the counter keeps counting (to the compare value and beyond).
- R5: In mode 11 a match inverts the pin and loads the counter with 0. The pin therefore changes every compare × prescale cycles.
- R6: A match sets the channel flag. The flag holds until a `flag_clr` pulse. A match and a clear in the same cycle leave the flag set.
- R7: `tb_sel` routes the counters to the channels. With 00, counter A feeds both channels. With 01, A feeds channel 0 and B feeds channel 1. With 10 or 11, B feeds both channels.
- R8: With `tmr_wide` low, the counter wraps from 0xFF to 0x00, its high byte stays 0 (a high-byte write is dropped), and only the low bytes are compared.
- R9: Mode 00 makes no match, so the pin and the flag are untouched.
- R10: A counter with its run bit low holds its value and causes no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_run | input | 2 | Run bit per counter (bit 0 = A, bit 1 = B) |
| tmr_wide | input | 2 | 1 = 16-bit counter form, 0 = 8-bit form, per counter |
| presc_code | input | 2 | Prescale code shared by both counters |
| tb_sel | input | 2 | Time-base routing code |
| ch_mode | input | 4 | Match action, 2 bits per channel (channel 0 in bits 1:0) |
| wr_en | input | 1 | Byte write strobe |
| wr_tgt | input | 2 | Write target register |
| wr_hi | input | 1 | Byte lane of the write |
| wr_data | input | 8 | Write byte |
| flag_clr | input | 2 | Clear pulse per channel flag |
| wave_out | output | 2 | Channel output pins |
| match_flag | output | 2 | Sticky match flags |
| tmr_val | output | 32 | Counter values, A in bits 15:0 |
| cmp_val | output | 32 | Compare values, channel 0 in bits 15:0 |

## Verification
Two events can fall on the same clock edge: a compare match setting a flag and a software clear of that flag. The bench starts from a set flag, runs the counter to one step short of the threshold, and raises the clear pulse exactly for the edge of the match. The flag must still read 1 after that edge. A clear on the next edge, with no match present, must bring the flag to 0. A second overlap is a counter reload by the invert action on the same edge as the pin update. The bench checks it by reading counter zero and the inverted pin together, and a scoreboard compares every later pin edge against cycle numbers predicted from the threshold and the prescale.

// File: rtl/cmp_wave_pkg.sv
package cmp_wave_pkg;

  localparam int NUM_CH  = 2;
  localparam int NUM_TMR = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_HIGH   = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_TOGGLE = 2'b11
  } match_act_e;

  // Which counter feeds channel ch: 0 = counter A, 1 = counter B.
  function automatic logic src_of(input logic [1:0] sel, input int ch);
    logic b;
    case (sel)
      2'b00:   b = 1'b0;
      2'b01:   b = (ch != 0);
      default: b = 1'b1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/cwg_prescaler.sv
module cwg_prescaler #(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);
  localparam int PCNT_W = (1 << PS_W) - 1;
  localparam logic [PCNT_W-1:0] PCNT_ONE = {{(PCNT_W-1){1'b0}}, 1'b1};

  // Low "code" bits set: the value at which a divide-by-2^code stage fires.
  function automatic logic [PCNT_W-1:0] div_mask(input logic [PS_W-1:0] c);
    logic [PCNT_W-1:0] m;
    m = '0;
    for (int i = 0; i < PCNT_W; i++)
      if (i < int'(c)) m[i] = 1'b1;
    return m;
  endfunction

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] mask;

  assign mask = div_mask(code);
  assign tick = run && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else                pcnt <= pcnt + PCNT_ONE;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != '0) |=> (!tick || code == '0));

endmodule

// File: rtl/cwg_timebase.sv
module cwg_timebase #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              clear_req,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c, input logic w);
    logic [CNT_W-1:0] n;
    n = c + CNT_ONE;
    if (!w) n[CNT_W-1:BYTE_W] = '0;
    return n;
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo)          cnt_d[BYTE_W-1:0] = wr_byte;
    else if (wr_hi)     cnt_d[CNT_W-1:BYTE_W] = HI_W'(wr_byte);
    else if (tick)      cnt_d = clear_req ? '0 : step(cnt_q, wide);
    if (!wide)          cnt_d[CNT_W-1:BYTE_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && clear_req && !wr_lo && !wr_hi) |=> (count == '0));

  // R8
  narrow_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide) |=> (count[CNT_W-1:BYTE_W] == '0));

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lo && !wr_hi && wide) |=> $stable(count));

endmodule

// File: rtl/cwg_channel.sv
module cwg_channel
  import cmp_wave_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  match_act_e        mode,
  input  logic              wide,
  input  logic [CNT_W-1:0]  count,
  input  logic              tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              match,
  output logic              clear_req,
  output logic              pin,
  output logic              flag
);
  localparam int HI_W = CNT_W - BYTE_W;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // The counter is about to step onto the threshold.
  function automatic logic hits(input logic [CNT_W-1:0] c,
                                input logic [CNT_W-1:0] thr,
                                input logic w);
    logic [CNT_W-1:0] n;
    n = c + CNT_ONE;
    return w ? (n == thr) : (n[BYTE_W-1:0] == thr[BYTE_W-1:0]);
  endfunction

  logic pin_q, flag_q;

  assign match     = tick && (mode != ACT_NONE) && hits(count, cmp_q, wide);
  assign clear_req = match && (mode == ACT_TOGGLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
    end else if (wr_lo) begin
      cmp_q[BYTE_W-1:0] <= wr_byte;
    end else if (wr_hi) begin
      cmp_q[CNT_W-1:BYTE_W] <= HI_W'(wr_byte);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (match) begin
      case (mode)
        ACT_HIGH:   pin_q <= 1'b1;
        ACT_LOW:    pin_q <= 1'b0;
        ACT_TOGGLE: pin_q <= ~pin_q;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (match)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign pin  = pin_q;
  assign flag = flag_q;

  // R4
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == ACT_HIGH) |=> pin);

  // R4
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && mode == ACT_LOW) |=> !pin);

  // R5
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> (pin != $past(pin)));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  // R9
  idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACT_NONE) |=> ($stable(pin) && (flag || !$past(flag) || $past(flag_clr))));

endmodule

// File: rtl/cmp_wave_gen.sv
module cmp_wave_gen
  import cmp_wave_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int PS_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_TMR-1:0]        tmr_run,
  input  logic [NUM_TMR-1:0]        tmr_wide,
  input  logic [PS_W-1:0]           presc_code,
  input  logic [1:0]                tb_sel,
  input  logic [2*NUM_CH-1:0]       ch_mode,
  input  logic                      wr_en,
  input  logic [1:0]                wr_tgt,
  input  logic                      wr_hi,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [NUM_CH-1:0]         flag_clr,
  output logic [NUM_CH-1:0]         wave_out,
  output logic [NUM_CH-1:0]         match_flag,
  output logic [NUM_TMR*CNT_W-1:0]  tmr_val,
  output logic [NUM_CH*CNT_W-1:0]   cmp_val
);
  logic [CNT_W-1:0]   t_count [NUM_TMR];
  logic [NUM_TMR-1:0] t_tick;
  logic [NUM_TMR-1:0] t_clr;
  logic [NUM_CH-1:0]  ch_src;
  logic [NUM_CH-1:0]  ch_match;
  logic [NUM_CH-1:0]  ch_clr;

  // A counter is sent to zero when any invert-mode channel it feeds matches.
  always_comb begin
    t_clr = '0;
    for (int t = 0; t < NUM_TMR; t++)
      for (int c = 0; c < NUM_CH; c++)
        if (ch_clr[c] && (ch_src[c] == (t != 0))) t_clr[t] = 1'b1;
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic tw;
    assign tw = wr_en && (wr_tgt == 2'(NUM_CH + t));

    cwg_prescaler #(.PS_W(PS_W)) u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run[t]),
      .code  (presc_code),
      .tick  (t_tick[t])
    );

    cwg_timebase #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (t_tick[t]),
      .wide      (tmr_wide[t]),
      .wr_lo     (tw && !wr_hi),
      .wr_hi     (tw && wr_hi),
      .wr_byte   (wr_data),
      .clear_req (t_clr[t]),
      .count     (t_count[t])
    );

    assign tmr_val[t*CNT_W +: CNT_W] = t_count[t];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic cw;
    assign ch_src[c] = src_of(tb_sel, c);
    assign cw        = wr_en && (wr_tgt == 2'(c));

    cwg_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (match_act_e'(ch_mode[2*c +: 2])),
      .wide      (ch_src[c] ? tmr_wide[1] : tmr_wide[0]),
      .count     (ch_src[c] ? t_count[1] : t_count[0]),
      .tick      (ch_src[c] ? t_tick[1] : t_tick[0]),
      .wr_lo     (cw && !wr_hi),
      .wr_hi     (cw && wr_hi),
      .wr_byte   (wr_data),
      .flag_clr  (flag_clr[c]),
      .cmp_q     (cmp_val[c*CNT_W +: CNT_W]),
      .match     (ch_match[c]),
      .clear_req (ch_clr[c]),
      .pin       (wave_out[c]),
      .flag      (match_flag[c])
    );
  end

  // R10
  stopped_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_run == '0) |-> (ch_match == '0));

  // R7
  route_b_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_sel[1] && !tmr_run[1]) |-> (ch_match == '0));

  // R7
  route_a_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_sel == 2'b00 && !tmr_run[0]) |-> (ch_match == '0));

endmodule

// File: tb/cmp_wave_gen_tb_top.sv
`timescale 1ns/1ps
module cmp_wave_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  tmr_run, tmr_wide, presc_code, tb_sel, wr_tgt, flag_clr;
  logic [3:0]  ch_mode;
  logic        wr_en, wr_hi;
  logic [7:0]  wr_data;
  logic [1:0]  wave_out, match_flag;
  logic [31:0] tmr_val, cmp_val;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  logic prev0 = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmp_wave_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tmr_run(tmr_run), .tmr_wide(tmr_wide),
    .presc_code(presc_code), .tb_sel(tb_sel), .ch_mode(ch_mode),
    .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_hi(wr_hi), .wr_data(wr_data),
    .flag_clr(flag_clr), .wave_out(wave_out), .match_flag(match_flag),
    .tmr_val(tmr_val), .cmp_val(cmp_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every edge of channel-0 pin is matched against the predicted cycle.
  always @(negedge clk) begin
    if (mon_on && wave_out[0] !== prev0) begin
      if (exp_q.size() == 0) chk("R5 unexpected pin edge", 32'(cyc), 32'hFFFF_FFFF);
      else chk("R5 pin edge cycle", 32'(cyc), 32'(exp_q.pop_front()));
    end
    prev0 = wave_out[0];
  end

  task automatic wr(input logic [1:0] tgt, input logic hi, input logic [7:0] d);
    wr_en = 1'b1; wr_tgt = tgt; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load16(input logic [1:0] tgt, input logic [15:0] v);
    wr(tgt, 1'b1, v[15:8]);
    wr(tgt, 1'b0, v[7:0]);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] base;
    rst_n = 1'b0; tmr_run = '0; tmr_wide = 2'b11; presc_code = '0; tb_sel = '0;
    ch_mode = '0; wr_en = 1'b0; wr_tgt = '0; wr_hi = 1'b0; wr_data = '0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins", 32'(wave_out), 0);
    chk("R1 flags", 32'(match_flag), 0);
    chk("R1 counters", tmr_val, 0);
    chk("R1 compare", cmp_val, 0);

    // R2 prescale sweep on counter A
    for (int code = 0; code < 4; code++) begin
      presc_code = 2'(code);
      base = tmr_val[15:0];
      tmr_run[0] = 1'b1;
      repeat (16) @(negedge clk);
      tmr_run[0] = 1'b0;
      chk("R2 advance per prescale", 32'(tmr_val[15:0] - base), 32'(16 >> code));
      @(negedge clk);
    end
    base = tmr_val[15:0];
    repeat (5) @(negedge clk);
    chk("R10 stopped counter holds", 32'(tmr_val[15:0]), 32'(base));

    // R3 byte lanes
    wr(2'b00, 1'b0, 8'h34);
    chk("R3 low byte", 32'(cmp_val[15:0]), 32'h0034);
    wr(2'b00, 1'b1, 8'h12);
    chk("R3 high byte", 32'(cmp_val[15:0]), 32'h1234);
    wr(2'b00, 1'b0, 8'h56);
    chk("R3 low keeps high", 32'(cmp_val[15:0]), 32'h1256);
    base = tmr_val[15:0];
    wr(2'b10, 1'b1, 8'hAB);
    chk("R3 counter high byte", 32'(tmr_val[15:0]), {16'h0, 8'hAB, base[7:0]});
    chk("R3 other compare untouched", 32'(cmp_val[31:16]), 0);

    // R4 force high, counter keeps going
    presc_code = 2'b00;
    load16(2'b10, 16'h0000);
    load16(2'b00, 16'd10);
    ch_mode[1:0] = 2'b01;
    tmr_run[0] = 1'b1;
    repeat (9) @(negedge clk);
    chk("R4 before match pin", 32'(wave_out[0]), 0);
    chk("R4 before match count", 32'(tmr_val[15:0]), 9);
    @(negedge clk);
    chk("R4 set-high pin", 32'(wave_out[0]), 1);
    chk("R6 flag on match", 32'(match_flag[0]), 1);
    @(negedge clk);
    chk("R4 counter not cleared", 32'(tmr_val[15:0]), 11);

    // R6 sticky flag and clear
    repeat (3) @(negedge clk);
    chk("R6 flag held", 32'(match_flag[0]), 1);
    flag_clr[0] = 1'b1;
    @(negedge clk);
    flag_clr[0] = 1'b0;
    chk("R6 flag cleared", 32'(match_flag[0]), 0);
    tmr_run[0] = 1'b0;

    // R4 force low
    load16(2'b10, 16'h0000);
    ch_mode[1:0] = 2'b10;
    tmr_run[0] = 1'b1;
    repeat (9) @(negedge clk);
    chk("R4 pin before set-low", 32'(wave_out[0]), 1);
    @(negedge clk);
    chk("R4 set-low pin", 32'(wave_out[0]), 0);
    tmr_run[0] = 1'b0;

    // R6 match and clear on the same edge
    load16(2'b10, 16'h0000);
    tmr_run[0] = 1'b1;
    repeat (9) @(negedge clk);
    flag_clr[0] = 1'b1;
    @(negedge clk);
    chk("R6 match beats clear", 32'(match_flag[0]), 1);
    @(negedge clk);
    chk("R6 clear without match", 32'(match_flag[0]), 0);
    flag_clr[0] = 1'b0;
    tmr_run[0] = 1'b0;

    // R9 idle mode
    ch_mode[1:0] = 2'b00;
    load16(2'b10, 16'h0000);
    tmr_run[0] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R9 no flag in idle mode", 32'(match_flag[0]), 0);
    chk("R9 pin untouched", 32'(wave_out[0]), 0);
    tmr_run[0] = 1'b0;

    // R5 invert mode, divide by 2, threshold 5: edge every 10 cycles
    presc_code = 2'b01;
    load16(2'b10, 16'h0000);
    load16(2'b00, 16'd5);
    ch_mode[1:0] = 2'b11;
    for (int k = 1; k <= 4; k++) exp_q.push_back(cyc + 10 * k);
    mon_on = 1'b1;
    tmr_run[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 counter reloaded", 32'(tmr_val[15:0]), 0);
    chk("R5 pin inverted", 32'(wave_out[0]), 1);
    repeat (35) @(negedge clk);
    tmr_run[0] = 1'b0;
    mon_on = 1'b0;
    chk("R5 all predicted edges seen", 32'(exp_q.size()), 0);

    // R8 narrow counter
    presc_code = 2'b00;
    ch_mode[1:0] = 2'b00;
    tmr_wide[0] = 1'b0;
    wr(2'b10, 1'b1, 8'h12);
    chk("R8 high write dropped", 32'(tmr_val[15:8]), 0);
    wr(2'b10, 1'b0, 8'hFE);
    tmr_run[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 wrap at 0xFF", 32'(tmr_val[15:0]), 0);
    tmr_run[0] = 1'b0;
    load16(2'b00, 16'hAB03);
    ch_mode[1:0] = 2'b01;
    tmr_run[0] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 pin before low-byte match", 32'(wave_out[0]), 0);
    @(negedge clk);
    chk("R8 low-byte match", 32'(wave_out[0]), 1);
    tmr_run[0] = 1'b0;

    // R7 routing
    tb_sel = 2'b01;
    tmr_wide = 2'b10;
    ch_mode = 4'b0110;
    load16(2'b01, 16'd4);
    load16(2'b11, 16'h0000);
    tmr_run = 2'b10;
    repeat (3) @(negedge clk);
    chk("R7 ch1 before match", 32'(wave_out[1]), 0);
    @(negedge clk);
    chk("R7 ch1 follows counter B", 32'(wave_out[1]), 1);
    chk("R7 ch1 flag", 32'(match_flag[1]), 1);
    chk("R7 ch0 stays on stopped A", 32'(wave_out[0]), 1);
    tmr_run = 2'b00;
    tb_sel = 2'b10;
    ch_mode = 4'b0010;
    load16(2'b00, 16'd6);
    load16(2'b11, 16'h0000);
    tmr_run = 2'b10;
    repeat (5) @(negedge clk);
    chk("R7 ch0 before B match", 32'(wave_out[0]), 1);
    @(negedge clk);
    chk("R7 ch0 follows counter B", 32'(wave_out[0]), 0);
    tmr_run = 2'b00;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule